// File: doc/BRIEF.md
# Overflow-Armed Taken-Branch Sample Buffer

This block collects short histories of taken control-flow changes for statistical profiling. A down-counter counts a sampling event against a programmable period. When the period runs out, the block arms a 16-entry record window. After one cycle of arming latency, the window stores the source and target address of every taken-branch strobe until it holds 16 records. Only then does it raise an interrupt request. The event counter keeps running throughout, reloading from the period each time it wraps.

Software programs the period, which must exceed the window depth. It reads records through an index port, where index 0 is the newest record. It then clears and re-arms the block with a single strobe. While the core signals a low-power state, no branch is recorded. An armed window resumes filling when that state ends.

Top module: `brs_top`

## Requirements
- R1: After reset the remaining count, fill count, interrupt and configuration-error outputs are all zero, and the block is idle (events are not counted).
- R2: A period write with a value greater than 16 loads the period and the remaining count, empties the window, clears the interrupt and the configuration error, and starts counting. A value of 16 or less sets the configuration error and is otherwise ignored.
- R3: While counting, each event pulse decrements the remaining count by one, and no branch is recorded.
- R4: An event that arrives when the remaining count is 1 overflows the counter and arms the window. Branches in the overflow cycle and in the following cycle are not recorded.
- R5: Once armed, every branch strobe is recorded, one per cycle, with no filtering, and the fill count rises by one per record.
- R6: The window saturates at 16 records. Further strobes change neither the fill count nor the stored records until a clear.
- R7: The interrupt stays low until the 16th record is captured. It is high from the next cycle and stays high until a clear or a valid period write.
- R8: Events keep being counted while the block is armed, filling or full. At 1, the count reloads from the period without starting a new arming.
- R9: The read index selects records newest-first: index 0 returns the latest source/target pair. Any index at or above the fill count returns zero on both address outputs.
- R10: A branch strobe seen while the low-power input is high is not recorded. An armed window resumes recording after the input falls.
- R11: A re-arm strobe empties the window, clears the interrupt, reloads the remaining count from the period and returns to counting (only when a valid period is set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Sampling event pulse |
| br_vld_i | input | 1 | Retired taken-branch strobe |
| br_src_i | input | ADDR_W | Branch source address |
| br_dst_i | input | ADDR_W | Branch target address |
| lowpwr_i | input | 1 | Core is in a low-power state |
| prd_wr_i | input | 1 | Period write strobe |
| prd_data_i | input | CNT_W | Period value to write |
| rearm_i | input | 1 | Clear and re-arm strobe |
| rd_idx_i | input | IDX_W | Read index, 0 = newest |
| rd_src_o | output | ADDR_W | Source address at read index |
| rd_dst_o | output | ADDR_W | Target address at read index |
| fill_o | output | FILL_W | Number of held records, 0 to 16 |
| remain_o | output | CNT_W | Events left until the counter wraps |
| irq_o | output | 1 | Interrupt request, window full |
| cfg_err_o | output | 1 | Last period write was rejected |

## Verification
The window is driven with branch strobes on every cycle across the overflow boundary. This shows whether the overflow cycle and the arming cycle are really excluded. Low-power pulses are placed both in the middle of a fill and across the arming cycle, which separates a gate on capture from a gate on arming. Events keep running through a full window and past a counter wrap, which exposes any re-arming or stall on overflow. Readback at every index, both for a full window and a partial one, catches errors in ordering and in the zero fill above the count. A reference model in the bench tracks the count, fill and interrupt cycle by cycle, and a queue of expected records is compared as each capture appears.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COUNT = 3'd1,
    ST_ARM   = 3'd2,
    ST_REC   = 3'd3,
    ST_FULL  = 3'd4
  } brs_state_e;
endpackage

// File: rtl/brs_period_ctr.sv
module brs_period_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             run_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;
  logic             at_one;

  assign at_one = (rem_q == CNT_W'(1));
  assign wrap_o = run_i & evt_i & at_one & ~load_i;

  always_comb begin
    rem_en = load_i | (run_i & evt_i);
    if (load_i)      rem_d = load_val_i;
    else if (at_one) rem_d = reload_val_i;
    else             rem_d = rem_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign rem_o = rem_q;
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              go_i,
  input  logic              wrap_i,
  input  logic              br_vld_i,
  input  logic              lowpwr_i,
  input  logic [FILL_W-1:0] fill_i,
  output brs_state_e        state_o,
  output logic              cap_o,
  output logic              run_o,
  output logic              irq_o
);
  brs_state_e st_q, st_d;
  logic       irq_q, irq_d, irq_en;
  logic       last_slot;
  logic       cap;

  assign last_slot = (fill_i == FILL_W'(DEPTH - 1));
  assign cap       = (st_q == ST_REC) & br_vld_i & ~lowpwr_i & ~clr_i;

  always_comb begin
    st_d   = st_q;
    irq_d  = irq_q;
    irq_en = 1'b0;
    if (clr_i) begin
      st_d   = go_i ? ST_COUNT : ST_IDLE;
      irq_d  = 1'b0;
      irq_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_COUNT: if (wrap_i) st_d = ST_ARM;
        ST_ARM:   st_d = ST_REC;
        ST_REC: begin
          if (cap && last_slot) begin
            st_d   = ST_FULL;
            irq_d  = 1'b1;
            irq_en = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign state_o = st_q;
  assign cap_o   = cap;
  assign run_o   = (st_q != ST_IDLE);
  assign irq_o   = irq_q;
endmodule

// File: rtl/brs_store.sv
module brs_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [FILL_W-1:0] fill_o,
  output logic [ADDR_W-1:0] rd_src_o,
  output logic [ADDR_W-1:0] rd_dst_o
);
  logic [FILL_W-1:0]             fill_q, fill_d;
  logic                          fill_en;
  logic                          cap_ok;
  logic [DEPTH-1:0][ADDR_W-1:0]  src_all, dst_all;
  logic [FILL_W-1:0]             phys_w;
  logic [IDX_W-1:0]              phys;
  logic                          hit;

  assign cap_ok = cap_i & (fill_q != FILL_W'(DEPTH));

  always_comb begin
    fill_en = clr_i | cap_ok;
    fill_d  = clr_i ? '0 : fill_q + FILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              we;
    logic [ADDR_W-1:0] s_q, d_q;
    assign we = cap_ok & ~clr_i & (fill_q == FILL_W'(g));
    always_ff @(posedge clk) begin
      if (we) begin
        s_q <= src_i;
        d_q <= dst_i;
      end
    end
    assign src_all[g] = s_q;
    assign dst_all[g] = d_q;
  end

  assign hit    = (FILL_W'(rd_idx_i) < fill_q);
  assign phys_w = fill_q - FILL_W'(1) - FILL_W'(rd_idx_i);
  assign phys   = phys_w[IDX_W-1:0];

  assign rd_src_o = hit ? src_all[phys] : '0;
  assign rd_dst_o = hit ? dst_all[phys] : '0;
  assign fill_o   = fill_q;
endmodule

// File: rtl/brs_top.sv
module brs_top
  import brs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              br_vld_i,
  input  logic [ADDR_W-1:0] br_src_i,
  input  logic [ADDR_W-1:0] br_dst_i,
  input  logic              lowpwr_i,
  input  logic              prd_wr_i,
  input  logic [CNT_W-1:0]  prd_data_i,
  input  logic              rearm_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_src_o,
  output logic [ADDR_W-1:0] rd_dst_o,
  output logic [FILL_W-1:0] fill_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              irq_o,
  output logic              cfg_err_o
);
  logic [CNT_W-1:0] period_q;
  logic             period_set_q;
  logic             cfg_err_q;
  logic             prd_ok, valid_wr, clr, go;
  logic             wrap, run, cap;
  logic [CNT_W-1:0] load_val;
  brs_state_e       st;

  assign prd_ok   = (prd_data_i > CNT_W'(DEPTH));
  assign valid_wr = prd_wr_i & prd_ok;
  assign clr      = valid_wr | (rearm_i & ~prd_wr_i);
  assign go       = valid_wr | (rearm_i & ~prd_wr_i & period_set_q);
  assign load_val = valid_wr ? prd_data_i : period_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q     <= '0;
      period_set_q <= 1'b0;
    end else if (valid_wr) begin
      period_q     <= prd_data_i;
      period_set_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_err_q <= 1'b0;
    else if (prd_wr_i) cfg_err_q <= ~prd_ok;
  end

  brs_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (go),
    .load_val_i   (load_val),
    .reload_val_i (period_q),
    .run_i        (run),
    .evt_i        (evt_i),
    .rem_o        (remain_o),
    .wrap_o       (wrap)
  );

  brs_ctrl #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .go_i     (go),
    .wrap_i   (wrap),
    .br_vld_i (br_vld_i),
    .lowpwr_i (lowpwr_i),
    .fill_i   (fill_o),
    .state_o  (st),
    .cap_o    (cap),
    .run_o    (run),
    .irq_o    (irq_o)
  );

  brs_store #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .FILL_W (FILL_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .cap_i    (cap),
    .src_i    (br_src_i),
    .dst_i    (br_dst_i),
    .rd_idx_i (rd_idx_i),
    .fill_o   (fill_o),
    .rd_src_o (rd_src_o),
    .rd_dst_o (rd_dst_o)
  );

  assign cfg_err_o = cfg_err_q;
endmodule

// File: rtl/brs_checker.sv
module brs_checker
  import brs_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DEPTH  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lowpwr_i,
  input logic              prd_wr_i,
  input logic [CNT_W-1:0]  prd_data_i,
  input logic              rearm_i,
  input logic [FILL_W-1:0] fill_o,
  input logic              irq_o,
  input logic              cfg_err_o,
  input brs_state_e        state_i
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= FILL_W'(DEPTH)); // R6
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == FILL_W'(DEPTH) && !rearm_i && !prd_wr_i) |=> fill_o == FILL_W'(DEPTH)); // R6
  AST_IRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> fill_o == FILL_W'(DEPTH)); // R7
  AST_NO_CAP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    state_i == ST_COUNT |-> fill_o == '0); // R3
  AST_ARM_SKID: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_ARM && !rearm_i && !prd_wr_i) |=> $stable(fill_o)); // R4
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rearm_i && !prd_wr_i) |=> (fill_o == $past(fill_o) || fill_o == $past(fill_o) + FILL_W'(1))); // R5
  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr_i && !rearm_i && !prd_wr_i) |=> $stable(fill_o)); // R10
  AST_REARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && !prd_wr_i) |=> (fill_o == '0 && !irq_o)); // R11
  AST_BAD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_wr_i && prd_data_i <= CNT_W'(DEPTH)) |=> cfg_err_o); // R2
endmodule

bind brs_top brs_checker #(
  .CNT_W  (CNT_W),
  .DEPTH  (DEPTH),
  .FILL_W (FILL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lowpwr_i   (lowpwr_i),
  .prd_wr_i   (prd_wr_i),
  .prd_data_i (prd_data_i),
  .rearm_i    (rearm_i),
  .fill_o     (fill_o),
  .irq_o      (irq_o),
  .cfg_err_o  (cfg_err_o),
  .state_i    (st)
);

// File: tb/brs_top_bench.sv
module brs_top_bench;
  localparam int DEPTH = 16;

  logic        clk;
  logic        rst_n;
  logic        evt_i, br_vld_i, lowpwr_i, prd_wr_i, rearm_i;
  logic [31:0] br_src_i, br_dst_i, prd_data_i;
  logic [3:0]  rd_idx_i;
  logic [31:0] rd_src_o, rd_dst_o, remain_o;
  logic [4:0]  fill_o;
  logic        irq_o, cfg_err_o;

  brs_top u_brs_top (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .br_vld_i(br_vld_i),
    .br_src_i(br_src_i), .br_dst_i(br_dst_i), .lowpwr_i(lowpwr_i),
    .prd_wr_i(prd_wr_i), .prd_data_i(prd_data_i), .rearm_i(rearm_i),
    .rd_idx_i(rd_idx_i), .rd_src_o(rd_src_o), .rd_dst_o(rd_dst_o),
    .fill_o(fill_o), .remain_o(remain_o), .irq_o(irq_o), .cfg_err_o(cfg_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model: 0 idle, 1 count, 2 arm, 3 rec, 4 full
  int          m_mode = 0;
  int          m_rem  = 0;
  int          m_per  = 0;
  int          m_fill = 0;
  bit          m_irq  = 0;
  bit          m_err  = 0;
  logic [31:0] log_src [DEPTH];
  logic [31:0] log_dst [DEPTH];
  logic [31:0] q_src [$];
  logic [31:0] q_dst [$];

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk(tag, "remain", remain_o, m_rem);
    chk(tag, "fill", fill_o, m_fill);
    chk(tag, "irq", irq_o, m_irq);
  endtask

  task automatic drive_idle();
    evt_i = 0; br_vld_i = 0; lowpwr_i = 0; prd_wr_i = 0; rearm_i = 0;
    br_src_i = '0; br_dst_i = '0; prd_data_i = '0;
  endtask

  task automatic cyc(bit e, bit b, logic [31:0] s, logic [31:0] d, bit lp, string tag);
    int om, nm;
    drive_idle();
    evt_i = e; br_vld_i = b; br_src_i = s; br_dst_i = d; lowpwr_i = lp;
    @(posedge clk);
    om = m_mode; nm = om;
    if (om == 2) nm = 3;
    if (om == 3 && b && !lp) begin
      q_src.push_back(s); q_dst.push_back(d);
      log_src[m_fill] = s; log_dst[m_fill] = d;
      m_fill++;
      if (m_fill == DEPTH) begin nm = 4; m_irq = 1; end
    end
    if (e && om != 0) begin
      if (m_rem == 1) begin
        m_rem = m_per;
        if (om == 1) nm = 2;
      end else m_rem--;
    end
    m_mode = nm;
    #3;
    chk_state(tag);
  endtask

  task automatic wr_period(logic [31:0] v);
    drive_idle();
    prd_wr_i = 1; prd_data_i = v;
    @(posedge clk);
    if (v > DEPTH) begin
      m_per = v; m_rem = v; m_mode = 1; m_fill = 0; m_irq = 0; m_err = 0;
    end else m_err = 1;
    #3;
    drive_idle();
    chk("R2", "cfg_err", cfg_err_o, m_err);
    chk_state("R2");
  endtask

  task automatic rearm();
    drive_idle();
    rearm_i = 1;
    @(posedge clk);
    if (m_per > DEPTH) begin m_mode = 1; m_rem = m_per; end
    m_fill = 0; m_irq = 0;
    #3;
    drive_idle();
    chk_state("R11");
  endtask

  task automatic rd_check(int idx, string tag);
    logic [31:0] es, ed;
    rd_idx_i = idx[3:0];
    #1;
    if (idx < m_fill) begin es = log_src[m_fill-1-idx]; ed = log_dst[m_fill-1-idx]; end
    else begin es = '0; ed = '0; end
    chk(tag, "rd_src", rd_src_o, es);
    chk(tag, "rd_dst", rd_dst_o, ed);
  endtask

  // monitor: compares each new record against the expected queue (R5)
  logic [4:0] mon_prev = '0;
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (fill_o == mon_prev + 5'd1 && rd_idx_i == 4'd0) begin
        if (q_src.size() == 0) begin
          chk("R5", "unexpected capture", fill_o, mon_prev);
        end else begin
          chk("R5", "captured src", rd_src_o, q_src.pop_front());
          chk("R5", "captured dst", rd_dst_o, q_dst.pop_front());
        end
      end
      mon_prev = fill_o;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    drive_idle();
    rd_idx_i = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(posedge clk); #3;
    // R1 reset state
    chk("R1", "remain", remain_o, 0);
    chk("R1", "fill", fill_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "cfg_err", cfg_err_o, 0);
    cyc(1, 0, 0, 0, 0, "R1");  // idle ignores events

    // R2 invalid period at the boundary, then valid
    wr_period(16);
    wr_period(20);

    // R3 counting with branches present
    for (int k = 0; k < 5; k++) cyc(1, 1, 32'h0BAD_0000 + k, 32'h0BAD_1000 + k, 0, "R3");
    for (int k = 0; k < 14; k++) cyc(1, 0, 0, 0, 0, "R3");
    // R4 overflow cycle and arm cycle both carry branches
    cyc(1, 1, 32'hDEAD_0001, 32'hDEAD_0002, 0, "R4");
    cyc(0, 1, 32'hDEAD_0003, 32'hDEAD_0004, 0, "R4");
    // R5 ten captures, events interleaved (R8)
    for (int k = 0; k < 10; k++) cyc(k[0], 1, 32'h1000 + k, 32'h2000 + k * 3, 0, "R5");
    // R10 low power gate mid-fill
    for (int k = 0; k < 3; k++) cyc(0, 1, 32'hEEEE_0000 + k, 32'hEEEE_1000, 1, "R10");
    // R7 last six captures, irq rises after the 16th
    for (int k = 10; k < 16; k++) cyc(1, 1, 32'h1000 + k, 32'h2000 + k * 3, 0, "R7");
    // R6 saturation
    for (int k = 0; k < 3; k++) cyc(0, 1, 32'hFFFF_0000 + k, 32'hFFFF_1000 + k, 0, "R6");
    // R8 events run through a counter wrap while full
    for (int k = 0; k < 25; k++) cyc(1, 0, 0, 0, 0, "R8");
    // R9 full readout newest-first
    for (int i = 0; i < DEPTH; i++) rd_check(i, "R9");
    rd_idx_i = '0;

    // R11 clear and re-arm; R9 empty readout
    rearm();
    rd_check(0, "R9");
    cyc(1, 1, 32'h7777_0000, 32'h7777_1000, 0, "R3");

    // second round: longer period, low power across arming
    wr_period(40);
    for (int k = 0; k < 39; k++) cyc(1, 0, 0, 0, 0, "R3");
    cyc(1, 1, 32'hAAAA_0000, 32'hAAAA_1000, 1, "R4");
    cyc(0, 1, 32'hAAAA_0001, 32'hAAAA_1001, 1, "R10");
    cyc(0, 1, 32'hAAAA_0002, 32'hAAAA_1002, 1, "R10");
    cyc(0, 1, 32'hAAAA_0003, 32'hAAAA_1003, 1, "R10");
    for (int k = 0; k < 5; k++) cyc(0, 1, ~(32'h4000 + k), 32'h5000 ^ (k << 8), 0, "R10");
    rd_check(3, "R9");
    rd_check(4, "R9");
    rd_check(7, "R9");
    rd_idx_i = '0;
    cyc(0, 0, 0, 0, 0, "R5");
    chk("R5", "pending records", q_src.size(), 0);
    finish_run();
  end
endmodule